// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous requester and an asynchronous static RAM of 262,144 four-bit words that shares one set of data pins for reads and writes. The requester raises `req` with a direction, an address and write data. The controller accepts the request only while `ready` is high. It then plays out the chip-enable, write-enable and output-enable sequence the memory needs, with every phase a whole number of clock cycles.

Four cycle counts set the timing: write pulse, write data setup, read access and bus turnaround. Each defaults to the smallest cycle count that covers the memory's nanosecond limit at the configured clock period. With the default 8 ns clock, the write pulse lasts 2 cycles, read access lasts 2 cycles and turnaround lasts 1 cycle. All memory-side outputs come straight from flip-flops, so the strobes do not glitch. The controller's data driver and the memory's output driver are kept apart by dedicated idle cycles whenever the transfer direction changes.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, `ready`=1, `mem_ce_n`=1, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rvalid`=0.
- R2: While no request is pending, chip enable, write enable and output enable stay high (inactive) and `mem_dq_oe` stays 0. `ready` is 1 exactly in this idle state.
- R3: A write runs as follows after the acceptance edge. First comes one setup cycle with `mem_ce_n`=0 and `mem_we_n`=1. Next, `mem_we_n`=0 for max(T_WP,T_DW) cycles (2 by default). Then comes one hold cycle with `mem_we_n`=1 and `mem_ce_n`=0. `ready` returns on the cycle after the hold cycle.
- R4: From the setup cycle through the hold cycle of a write, `mem_addr` equals the accepted address and `mem_dq_out` equals the accepted write data, with `mem_dq_oe`=1. The address never changes while `mem_we_n` is 0.
- R5: A read holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for T_RD cycles (2 by default). On the edge that ends access, `mem_dq_in` is registered into `rdata` and `rvalid` rises, in the same cycle that `ready` returns.
- R6: `rvalid` is high for exactly one cycle per read. `rdata` keeps its value afterwards until the next read completes.
- R7: When a request's direction differs from the previous accepted request, T_TURN cycles (1 by default) are inserted after acceptance. In those cycles all three strobes are high, `mem_dq_oe`=0 and `ready`=0. A request in the same direction as the previous one starts with no inserted cycles.
- R8: The first request after reset never gets turnaround cycles, whatever its direction.
- R9: `mem_oe_n`=0 never coincides with `mem_dq_oe`=1. `mem_we_n`=0 only occurs while `mem_ce_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request, accepted on an edge where `ready` is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 4 | Write data |
| ready | output | 1 | Idle; a request is accepted at the next edge |
| rdata | output | 4 | Registered read data |
| rvalid | output | 1 | One-cycle pulse when `rdata` is updated |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the controller's data driver |
| mem_dq_in | input | 4 | Data read from the memory pins |

## Verification
The embedded assertions guard the pin-level rules on every cycle. They check that the output enable and the data driver never overlap, and that write enable is low only with chip enable low. They also check that `ready` implies fully released pins, that the address and write data stay put while write enable is low, that each write pulse lasts at least its programmed length, and that `rvalid` lasts a single cycle. Other properties depend on request history, and only the directed scenarios can show them: the exact cycle each phase starts and ends, whether turnaround cycles appear for a direction change and disappear for repeats, the behaviour of the first request after reset, and that data written through a behavioural memory comes back intact on a later read.

// File: rtl/asram_ctrl_pkg.sv
// Package: shared state type and cycle-count helpers for the SRAM controller.
// Assumes limits and clock period are given in picoseconds.
package asram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_RACC
    } ctl_state_e;

    // Smallest whole number of cycles covering a limit, never below one.
    function automatic int ps_to_cycles(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_ctrl_timer.sv
// Module: phase down-counter. Loaded with N on entry to a phase, it raises
// expired during the N-th cycle of that phase. Assumes N >= 1.
module asram_ctrl_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Load a phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == CW'(1));

    // R3 / R5: a phase must last at least one cycle
    timer_nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/asram_ctrl_fsm.sv
// Module: sequencer for write, read and turnaround phases. Drives the memory
// strobes and the data-driver enable from flip-flops decoded from the next
// state. Assumes the timer reports expiry in the last cycle of a phase.
module asram_ctrl_fsm
    import asram_ctrl_pkg::*;
#(
    parameter int CW      = 2,
    parameter int T_PULSE = 2,
    parameter int T_RD    = 2,
    parameter int T_TURN  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic          expired,
    output logic          ready,
    output logic          accept,
    output logic          rd_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          dq_oe
);
    ctl_state_e state, nxt;
    logic       prev_vld;
    logic       last_wr;
    logic       nxt_wr_phase;

    // Next-state and phase-timer decode.
    always_comb begin
        nxt      = state;
        accept   = 1'b0;
        rd_done  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (req) begin
                accept = 1'b1;
                if (prev_vld && (last_wr != req_wr)) begin
                    nxt = ST_TURN; tmr_load = 1'b1; tmr_val = CW'(T_TURN);
                end else if (req_wr) begin
                    nxt = ST_WSET;
                end else begin
                    nxt = ST_RACC; tmr_load = 1'b1; tmr_val = CW'(T_RD);
                end
            end
            ST_TURN: if (expired) begin
                if (last_wr) nxt = ST_WSET;
                else begin
                    nxt = ST_RACC; tmr_load = 1'b1; tmr_val = CW'(T_RD);
                end
            end
            ST_WSET: begin
                nxt = ST_WPUL; tmr_load = 1'b1; tmr_val = CW'(T_PULSE);
            end
            ST_WPUL: if (expired) nxt = ST_WHLD;
            ST_WHLD: nxt = ST_IDLE;
            ST_RACC: if (expired) begin
                nxt = ST_IDLE; rd_done = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign nxt_wr_phase = (nxt == ST_WSET) || (nxt == ST_WPUL) || (nxt == ST_WHLD);

    // State and glitch-free pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            ready <= 1'b1;
        end else begin
            state <= nxt;
            ce_n  <= !(nxt_wr_phase || (nxt == ST_RACC));
            we_n  <= (nxt != ST_WPUL);
            oe_n  <= (nxt != ST_RACC);
            dq_oe <= nxt_wr_phase;
            ready <= (nxt == ST_IDLE);
        end
    end

    // Direction history used for turnaround decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld <= 1'b0;
            last_wr  <= 1'b0;
        end else if (accept) begin
            prev_vld <= 1'b1;
            last_wr  <= req_wr;
        end
    end

    // Checker counter: length of the current write-enable low pulse.
    logic [CW-1:0] lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                lo_cnt <= '0;
        else if (we_n)             lo_cnt <= '0;
        else if (lo_cnt != '1)     lo_cnt <= lo_cnt + 1'b1;
    end

    // R9
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);
    // R2
    ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce_n && we_n && oe_n && !dq_oe));
    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (lo_cnt >= CW'(T_PULSE)));
    // R7
    drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $past(oe_n));

endmodule

// File: rtl/asram_ctrl_dpath.sv
// Module: address, write-data and read-data registers. Captures the request
// on acceptance and the memory pins when the read phase ends.
module asram_ctrl_dpath #(
    parameter int AW = 18,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_done,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    // Hold address and write data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= addr;
            dq_out   <= wdata;
        end
    end

    // Register read data and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_done;
            if (rd_done) rdata <= mem_dq_in;
        end
    end

    // R4
    addr_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> ($stable(mem_addr) && $stable(dq_out)));
    // R6
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/asram_ctrl.sv
// Module: top of the asynchronous SRAM access controller. Derives cycle counts
// from picosecond limits and the clock period, and wires sequencer, timer
// and data path. Assumes the external tri-state buffer uses mem_dq_oe.
module asram_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 4,
    parameter int CLK_PS  = 8000,
    parameter int T_WP    = ps_to_cycles(10000, CLK_PS),
    parameter int T_DW    = ps_to_cycles(7000,  CLK_PS),
    parameter int T_RD    = ps_to_cycles(12000, CLK_PS),
    parameter int T_TURN  = ps_to_cycles(5000,  CLK_PS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int T_PULSE = max_of(T_WP, T_DW);
    localparam int T_MAX   = max_of(max_of(T_PULSE, T_RD), T_TURN);
    localparam int CW      = $clog2(T_MAX + 1);

    logic          accept;
    logic          rd_done;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          expired;

    asram_ctrl_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(expired)
    );

    asram_ctrl_fsm #(
        .CW(CW), .T_PULSE(T_PULSE), .T_RD(T_RD), .T_TURN(T_TURN)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .expired(expired), .ready(ready), .accept(accept),
        .rd_done(rd_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
    );

    asram_ctrl_dpath #(.AW(AW), .DW(DW)) dpath_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .addr(addr),
        .wdata(wdata), .rd_done(rd_done), .mem_dq_in(mem_dq_in),
        .we_n(mem_we_n), .mem_addr(mem_addr), .dq_out(mem_dq_out),
        .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: tb/asram_ctrl_tb_top.sv
// Directed bench: one task per scenario, a small behavioural memory, and a
// per-cycle pin monitor. Inputs are driven and outputs sampled on negedge.
module asram_ctrl_tb_top;
    localparam int WP   = 2;  // 10 ns over 8 ns, rounded up
    localparam int RD   = 2;  // 12 ns over 8 ns
    localparam int TURN = 1;  // 5 ns over 8 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [17:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic        ready, rvalid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  rdata, mem_dq_out, mem_dq_in;
    logic [17:0] mem_addr;
    logic [3:0]  model [0:255];
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .addr(addr),
        .wdata(wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: drives only in the read decode, captures on we rise.
    assign mem_dq_in = (!mem_ce_n && mem_we_n && !mem_oe_n) ? model[mem_addr[7:0]] : 4'h0;
    always @(posedge mem_we_n)
        if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) model[mem_addr[7:0]] = mem_dq_out;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Pin monitor for overlap rules (R9).
    always @(negedge clk) if (rst_n && !done) begin
        if (!mem_oe_n && mem_dq_oe) begin
            errors++; $display("FAIL R9 overlap: actual=oe_n0/dq_oe1 expected=disjoint");
        end
        if (!mem_we_n && mem_ce_n) begin
            errors++; $display("FAIL R9 we outside ce: actual=ce_n1 expected=ce_n0");
        end
    end

    // pins = {ready, ce_n, we_n, oe_n, dq_oe}
    task automatic do_write(input logic [17:0] a, input logic [3:0] d, input int turn);
        @(negedge clk);
        chk(ready == 1'b1, "R2", "ready before write", ready, 1);
        req = 1'b1; req_wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        for (int i = 0; i <= turn + WP + 2; i++) begin
            logic [4:0] e;
            int j;
            @(negedge clk);
            if (i == 0) begin req = 1'b0; wdata = ~d; addr = ~a; end
            j = i - turn;
            if (j < 0)            e = 5'b01110;
            else if (j == 0)      e = 5'b00111;
            else if (j <= WP)     e = 5'b00011;
            else if (j == WP + 1) e = 5'b00111;
            else                  e = 5'b11110;
            chk({ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == e,
                (j < 0) ? "R7" : "R3", "write pins",
                {ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, e);
            if (j >= 0 && j <= WP + 1) begin
                chk(mem_addr == a && mem_dq_out == d, "R4", "write addr/data",
                    {mem_addr, mem_dq_out}, {a, d});
            end
        end
    endtask

    task automatic do_read(input logic [17:0] a, input logic [3:0] exp_d, input int turn);
        @(negedge clk);
        chk(ready == 1'b1, "R2", "ready before read", ready, 1);
        req = 1'b1; req_wr = 1'b0; addr = a;
        @(posedge clk);
        for (int i = 0; i <= turn + RD + 1; i++) begin
            logic [4:0] e;
            int j;
            @(negedge clk);
            if (i == 0) begin req = 1'b0; addr = ~a; end
            j = i - turn;
            if (j < 0)        e = 5'b01110;
            else if (j < RD)  e = 5'b00100;
            else              e = 5'b11110;
            chk({ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == e,
                (j < 0) ? "R7" : "R5", "read pins",
                {ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, e);
            if (j >= 0 && j < RD) begin
                chk(rvalid == 1'b0 && mem_addr == a, "R5", "read addr, no strobe",
                    {rvalid, mem_addr}, {1'b0, a});
            end
            if (j == RD) begin
                chk(rvalid == 1'b1 && rdata == exp_d, "R5", "read data strobe",
                    {rvalid, rdata}, {1'b1, exp_d});
            end
            if (j == RD + 1) begin
                chk(rvalid == 1'b0 && rdata == exp_d, "R6", "rvalid single, data held",
                    {rvalid, rdata}, {1'b0, exp_d});
            end
        end
    endtask

    task automatic check_reset_idle();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk({ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rvalid} == 6'b111100,
                (i == 0) ? "R1" : "R2", "idle pins",
                {ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rvalid}, 6'b111100);
        end
    endtask

    initial begin
        for (int k = 0; k < 256; k++) model[k] = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rvalid} == 6'b111100,
            "R1", "pins in reset", {ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rvalid}, 6'b111100);
        rst_n = 1'b1;
        check_reset_idle();
        do_write(18'h00005, 4'hA, 0);     // R8: first op, no turnaround
        do_write(18'h3FFFF, 4'h5, 0);     // R7: same direction, no gap
        do_read (18'h00005, 4'hA, TURN);  // R7: write to read
        do_read (18'h3FFFF, 4'h5, 0);     // R7: read to read
        do_read (18'h000A0, 4'h0, 0);     // unwritten word
        do_write(18'h12345, 4'hC, TURN);  // R7: read to write
        do_read (18'h12345, 4'hC, TURN);
        check_reset_idle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        do_read (18'h00005, 4'hA, 0);     // R8: first op after reset is a read
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog R1-all: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule